// File: doc/BRIEF.md
# Asynchronous static RAM access controller

This block sits between a clocked host and an 8K x 8 asynchronous static RAM. The host offers one request at a time over a valid/ready handshake. A request carries a 13-bit word address, a write flag and a byte of write data. The controller turns the request into a timed sequence on the RAM pins. Those pins are two chip selects of opposite polarity, an active-low output enable, an active-low write enable and a data bus split into out, out-enable and in. A read returns its byte together with a one-clock done pulse. A write also ends with a done pulse.

Every interval is set from nanosecond minimums and the clock period. Each interval is converted to whole clocks by rounding up, with at least one clock. Between accesses the RAM is held deselected. Writes are ended by the write-enable edge while data is still driven. Before the data driver turns on, the output enable has been high long enough for the RAM's outputs to float.

Top module: `asram_ctrl`

## Requirements
- R1: While idle, `reqReady` is 1 and the RAM is in standby: `memSelN`=1, `memSelP`=0, `memReadEnN`=1, `memWriteEnN`=1, `memDoutEn`=0. This holds after reset.
- R2: A read holds `memSelN`=0, `memSelP`=1, `memReadEnN`=0 and `memWriteEnN`=1 for RD cycles. RD = max(ceil(tRC/clk), ceil(tACC/clk)+1), which is 26 at the defaults. The byte on `memDin` is sampled on the last of those cycles. `rspDone` and the new `rspData` appear one clock later, 27 clocks after the accepting edge.
- R3: A write keeps `memWriteEnN` low for PULSE cycles, with data driven throughout. The data stays driven for exactly one clock after `memWriteEnN` rises. PULSE is 15 at the defaults, enough for the write pulse, the data setup and the chip-select and address windows. The RAM then holds the written byte.
- R4: The data driver is never on while `memReadEnN` is low. Before the driver turns on, `memReadEnN` has been high for at least ceil(tOHZ/clk) clocks, which is 9 at the defaults.
- R5: From the accepting edge until the access ends, `reqReady` is 0. A request presented during that time is ignored: it changes no RAM content.
- R6: `rspDone` is a pulse of exactly one clock for each access, read or write.
- R7: The address on `memAddr` and the write data on `memDout` stay stable while the RAM is selected.
- R8: A write spans setup, pulse and recovery phases totalling at least ceil(tWC/clk) clocks. `rspDone` comes 26 clocks after the accepting edge at the defaults.
- R9: All 13 address bits reach the RAM. Words 0, 8191 and 0x1555 are stored and read back independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller idle and accepting |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 13 | Word address |
| reqWdata | input | 8 | Byte to write |
| rspData | output | 8 | Last byte read |
| rspDone | output | 1 | One-clock end-of-access pulse |
| memAddr | output | 13 | RAM address pins |
| memSelN | output | 1 | Active-low chip select |
| memSelP | output | 1 | Active-high chip select |
| memReadEnN | output | 1 | Active-low output enable |
| memWriteEnN | output | 1 | Active-low write enable |
| memDout | output | 8 | Data driven toward the RAM |
| memDoutEn | output | 1 | Data driver enable |
| memDin | input | 8 | Data returned by the RAM |

## Verification
The assertions assume that the host keeps `reqWrite`, `reqAddr` and `reqWdata` meaningful only on the accepting edge. The stimulus therefore changes them only at the falling clock edge and holds them through the edge that accepts. The bench's RAM model returns data only when both selects are active, output enable is low and write enable is high. It stores a byte on the rising edge of write enable while selected, so the model never drives during a write phase. The busy-period stimulus lowers `reqValid` before the access ends, so no held-off request is accepted later.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WSETUP,
    ST_WPULSE,
    ST_WREC
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;   // latch host request
    logic sample;    // latch RAM read data
    logic drive;     // data driver enable for next cycle
  } dpStrobes_t;

  function automatic int ceilCycles(int ns, int clkNs);
    int c;
    c = (ns + clkNs - 1) / clkNs;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int maxOf(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_ctrl_fsm.sv
module asram_ctrl_fsm
  import asram_pkg::*;
#(
  parameter int RD_CYC    = 26,
  parameter int SETUP_CYC = 9,
  parameter int PULSE_CYC = 15,
  parameter int REC_CYC   = 1,
  parameter int CNT_W     = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output logic       rspDone,
  output logic       memSelN,
  output logic       memSelP,
  output logic       memReadEnN,
  output logic       memWriteEnN,
  output dpStrobes_t strobes
);

  ctrlState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic lastCycle;

  assign lastCycle = (cnt == '0);
  assign reqReady  = (state == ST_IDLE);

  always_comb begin
    stateNext = state;
    cntNext   = lastCycle ? cnt : cnt - 1'b1;
    unique case (state)
      ST_IDLE: begin
        cntNext = '0;
        if (reqValid) begin
          stateNext = reqWrite ? ST_WSETUP : ST_READ;
          cntNext   = reqWrite ? CNT_W'(SETUP_CYC - 1) : CNT_W'(RD_CYC - 1);
        end
      end
      ST_READ: if (lastCycle) stateNext = ST_IDLE;
      ST_WSETUP: if (lastCycle) begin
        stateNext = ST_WPULSE;
        cntNext   = CNT_W'(PULSE_CYC - 1);
      end
      ST_WPULSE: if (lastCycle) begin
        stateNext = ST_WREC;
        cntNext   = CNT_W'(REC_CYC - 1);
      end
      ST_WREC: if (lastCycle) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_comb begin
    strobes.capture = reqReady && reqValid;
    strobes.sample  = (state == ST_READ) && lastCycle;
    // driver on through the pulse and for the first recovery clock only
    strobes.drive   = (stateNext == ST_WPULSE) ||
                      (stateNext == ST_WREC && state == ST_WPULSE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      rspDone     <= 1'b0;
      memSelN     <= 1'b1;
      memSelP     <= 1'b0;
      memReadEnN  <= 1'b1;
      memWriteEnN <= 1'b1;
    end else begin
      state       <= stateNext;
      cnt         <= cntNext;
      rspDone     <= ((state == ST_READ) || (state == ST_WREC)) && lastCycle;
      memSelN     <= (stateNext == ST_IDLE);
      memSelP     <= (stateNext != ST_IDLE);
      memReadEnN  <= (stateNext != ST_READ);
      memWriteEnN <= (stateNext != ST_WPULSE);
    end
  end

endmodule

// File: rtl/asram_datapath.sv
module asram_datapath
  import asram_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strobes,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDin,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic [DATA_W-1:0] rspData
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr   <= '0;
      memDout   <= '0;
      memDoutEn <= 1'b0;
      rspData   <= '0;
    end else begin
      if (strobes.capture) begin
        memAddr <= reqAddr;
        memDout <= reqWdata;
      end
      if (strobes.sample) rspData <= memDin;
      memDoutEn <= strobes.drive;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 13,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 4,
  parameter int T_RC_NS  = 100,
  parameter int T_ACC_NS = 100,
  parameter int T_WC_NS  = 100,
  parameter int T_WP_NS  = 60,
  parameter int T_DW_NS  = 50,
  parameter int T_CW_NS  = 80,
  parameter int T_AW_NS  = 80,
  parameter int T_OHZ_NS = 35
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspDone,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memSelN,
  output logic              memSelP,
  output logic              memReadEnN,
  output logic              memWriteEnN,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  input  logic [DATA_W-1:0] memDin
);

  localparam int RD_CYC    = maxOf(ceilCycles(T_RC_NS, CLK_NS),
                                   ceilCycles(T_ACC_NS, CLK_NS) + 1);
  localparam int SETUP_CYC = ceilCycles(T_OHZ_NS, CLK_NS);
  localparam int PULSE_CYC = maxOf(maxOf(ceilCycles(T_WP_NS, CLK_NS),
                                         ceilCycles(T_DW_NS, CLK_NS)),
                                   maxOf(ceilCycles(T_CW_NS, CLK_NS) - SETUP_CYC,
                                         ceilCycles(T_AW_NS, CLK_NS) - SETUP_CYC));
  localparam int REC_CYC   = maxOf(1, ceilCycles(T_WC_NS, CLK_NS) - SETUP_CYC - PULSE_CYC);
  localparam int MAX_CYC   = maxOf(maxOf(RD_CYC, SETUP_CYC), maxOf(PULSE_CYC, REC_CYC));
  localparam int CNT_W     = $clog2(MAX_CYC + 1);

  dpStrobes_t strobes;

  asram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .REC_CYC(REC_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .rspDone(rspDone), .memSelN(memSelN), .memSelP(memSelP),
    .memReadEnN(memReadEnN), .memWriteEnN(memWriteEnN), .strobes(strobes)
  );

  asram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memDin(memDin), .memAddr(memAddr),
    .memDout(memDout), .memDoutEn(memDoutEn), .rspData(rspData)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int DATA_W    = 8,
  parameter int PULSE_MIN = ceilCycles(60, 4)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspDone,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memDout,
  input logic              memSelN,
  input logic              memSelP,
  input logic              memReadEnN,
  input logic              memWriteEnN,
  input logic              memDoutEn
);

  logic selected;
  logic [7:0] weLowCnt;

  assign selected = !memSelN && memSelP;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) weLowCnt <= '0;
    else if (!memWriteEnN) weLowCnt <= weLowCnt + 8'd1;
    else weLowCnt <= '0;
  end

  assert_idle_standby_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memSelN && !memSelP && memReadEnN && memWriteEnN && !memDoutEn));

  assert_read_we_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    !memReadEnN |-> (selected && memWriteEnN));

  assert_we_low_driven_R3: assert property (@(posedge clk) disable iff (!rstN)
    !memWriteEnN |-> (selected && memDoutEn));

  assert_hold_after_we_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWriteEnN) |-> memDoutEn);

  assert_we_pulse_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWriteEnN) |-> (weLowCnt >= 8'(PULSE_MIN)));

  assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> memReadEnN);

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);

  assert_stable_pins_R7: assert property (@(posedge clk) disable iff (!rstN)
    (selected && $past(selected)) |-> ($stable(memAddr) && $stable(memDout)));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspDone(rspDone),
  .memAddr(memAddr), .memDout(memDout), .memSelN(memSelN), .memSelP(memSelP),
  .memReadEnN(memReadEnN), .memWriteEnN(memWriteEnN), .memDoutEn(memDoutEn)
);

// File: tb/tb_asram_ctrl.sv
`timescale 1ns/1ps
module tb_asram_ctrl;

  localparam int RD_LAT = 27;  // 26 read clocks + 1
  localparam int WR_LAT = 26;  // 9 + 15 + 1 write clocks + 1
  localparam int OHZ_CYC = 9;
  localparam int WP_CYC = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [12:0] reqAddr = '0;
  logic [7:0] reqWdata = '0;
  logic reqReady, rspDone, memSelN, memSelP, memReadEnN, memWriteEnN, memDoutEn;
  logic [7:0] rspData, memDout, memDin;
  logic [12:0] memAddr;

  int total = 0, bad = 0;
  logic [7:0] ram [0:8191];

  always #2 clk = ~clk;

  asram_ctrl dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspData(rspData), .rspDone(rspDone), .memAddr(memAddr),
    .memSelN(memSelN), .memSelP(memSelP), .memReadEnN(memReadEnN),
    .memWriteEnN(memWriteEnN), .memDout(memDout), .memDoutEn(memDoutEn),
    .memDin(memDin)
  );

  function automatic logic [7:0] initPat(int a);
    return 8'(a) ^ 8'(a >> 8) ^ 8'h5A;
  endfunction

  // RAM model
  assign memDin = (!memSelN && memSelP && !memReadEnN && memWriteEnN) ? ram[memAddr] : 8'h00;
  always @(posedge memWriteEnN)
    if (!memSelN && memSelP && memDoutEn) ram[memAddr] = memDout;

  // pin monitor, sampled away from the active edge
  int weRun = 0, lastWeRun = 0, oeRun = 0, lastOeRun = 0;
  int noDrive = 0, contention = 0, readWeLow = 0, badRelease = 0, badHold = 0;
  logic prevWeLow = 1'b0, prevDrive = 1'b0, checkRelease = 1'b0;
  always @(negedge clk) if (rstN) begin
    if (checkRelease && memDoutEn) badRelease++;
    checkRelease = 1'b0;
    if (!memWriteEnN) weRun++;
    if (memWriteEnN && prevWeLow) begin
      lastWeRun = weRun; weRun = 0;
      if (!memDoutEn) badHold++;
      checkRelease = 1'b1;
    end
    if (!memWriteEnN && !memDoutEn) noDrive++;
    if (memDoutEn && !memReadEnN) contention++;
    if (!memReadEnN && !memWriteEnN) readWeLow++;
    if (memReadEnN) oeRun++; else oeRun = 0;
    if (memDoutEn && !prevDrive) lastOeRun = oeRun;
    prevWeLow = !memWriteEnN;
    prevDrive = memDoutEn;
  end

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReq(input logic wr, input logic [12:0] a, input logic [7:0] d,
                       output logic [7:0] rd, output int lat);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1;
    while (!rspDone && lat < 200) begin
      @(negedge clk); lat++;
    end
    rd = rspData;
    @(negedge clk);
    check("R6", "done width", int'(rspDone), 0);
  endtask

  task automatic tReset();
    check("R1", "ready", int'(reqReady), 1);
    check("R1", "standby pins", int'({memSelN, memSelP, memReadEnN, memWriteEnN, memDoutEn}), 5'b10110);
    check("R6", "done at reset", int'(rspDone), 0);
  endtask

  task automatic tWriteRead();
    logic [7:0] r; int lat;
    doReq(1'b1, 13'd0, 8'hA5, r, lat);     check("R8", "write latency", lat, WR_LAT);
    check("R3", "we pulse width", lastWeRun, WP_CYC);
    doReq(1'b1, 13'd8191, 8'h3C, r, lat);
    doReq(1'b1, 13'h1555, 8'h81, r, lat);
    doReq(1'b0, 13'd0, 8'h00, r, lat);     check("R9", "word 0", int'(r), 8'hA5);
    check("R2", "read latency", lat, RD_LAT);
    doReq(1'b0, 13'd8191, 8'h00, r, lat);  check("R9", "word 8191", int'(r), 8'h3C);
    doReq(1'b0, 13'h1555, 8'h00, r, lat);  check("R9", "word 0x1555", int'(r), 8'h81);
    check("R3", "ram holds byte", int'(ram[13'h1555]), 8'h81);
  endtask

  task automatic tReadUntouched();
    logic [7:0] r; int lat;
    doReq(1'b0, 13'd100, 8'h00, r, lat);
    check("R2", "read initial pattern", int'(r), int'(initPat(100)));
    check("R1", "standby after read", int'({memSelN, memSelP, memReadEnN}), 3'b101);
  endtask

  task automatic tBusyIgnore();
    logic [7:0] r; int lat;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 13'd200; reqWdata = 8'h11;
    @(posedge clk);
    @(negedge clk);
    check("R5", "ready while busy", int'(reqReady), 0);
    reqAddr = 13'd300; reqWdata = 8'hEE;       // valid still high: must be ignored
    repeat (5) @(negedge clk);
    check("R5", "ready still low", int'(reqReady), 0);
    reqValid = 1'b0;
    lat = 6;
    while (!rspDone && lat < 200) begin @(negedge clk); lat++; end
    check("R8", "busy write latency", lat, WR_LAT);
    doReq(1'b0, 13'd300, 8'h00, r, lat);
    check("R5", "held-off write ignored", int'(r), int'(initPat(300)));
    doReq(1'b0, 13'd200, 8'h00, r, lat);
    check("R3", "accepted write stored", int'(r), 8'h11);
  endtask

  task automatic tTurnaround();
    logic [7:0] r; int lat;
    doReq(1'b0, 13'd7, 8'h00, r, lat);
    doReq(1'b1, 13'd8, 8'h99, r, lat);
    check("R4", "oe high before drive", int'(lastOeRun >= OHZ_CYC + 1), 1);
    doReq(1'b0, 13'd8, 8'h00, r, lat);
    check("R4", "turnaround data", int'(r), 8'h99);
  endtask

  initial begin
    for (int i = 0; i < 8192; i++) ram[i] = initPat(i);
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    tReset();
    tWriteRead();
    tReadUntouched();
    tBusyIgnore();
    tTurnaround();
    check("R3", "driver off while we low", noDrive, 0);
    check("R3", "drive one clock after we rise", badHold, 0);
    check("R3", "release after hold clock", badRelease, 0);
    check("R4", "contention cycles", contention, 0);
    check("R2", "we low during read", readWeLow, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule